// File: doc/BRIEF.md
# Module Clock Enable/Disable Sequencer

This block switches the functional clock of a single peripheral module on or off. It works by driving that module's clock-control register and the handshake with the parent clock domain. A one-cycle command, acknowledged in the same cycle, selects enable or disable.

For an enable, the block first asks the clock domain for its clock and waits for a grant. It then reads the control register, replaces the 2-bit mode field and writes the register back. After that it re-reads the register, with a minimum spacing between reads, until the 2-bit idle-status field shows the module is usable or a microsecond timeout expires. A disable rewrites the mode field to zero and polls for the disabled status. It gives the domain back only after the polling has ended, whether the module reached the disabled status or the wait timed out.

Each sequence ends with a one-cycle done pulse that carries an error flag and a 2-bit error code. A standby output mirrors bit 18 of the most recent register read.

Top module: `modclk_seq`

## Requirements
- R1: Out of reset, `dom_req_o`, `done_o`, `err_o`, `reg_rd_o`, `reg_wr_o`, `cmd_ack_o` and `standby_o` are all low.
- R2: A command is accepted only while the block is idle, and `cmd_ack_o` is high in the same cycle as `cmd_req_i`. A request made while a sequence is running gets no acknowledge and changes neither the running sequence nor the register.
- R3: An enable raises `dom_req_o` before any register access. If `dom_fail_i` answers instead of `dom_gnt_i`, the block ends with error code 1, performs no register read or write, and drops `dom_req_o`.
- R4: The register update is a read-modify-write. Bits [1:0] become `cfg_mode_i` for an enable and 0 for a disable, and every other bit written back equals the bit that was read.
- R5: Idle status is read from bits [17:16]. An enable completes when it reads 0 (functional) or 2 (interface idle). A disable completes only when it reads 3 (disabled).
- R6: If an enable is not ready within EN_TMO_US microseconds (CLK_MHZ cycles each) after the write, the block ends with error code 2 and keeps the domain requested.
- R7: If a disable does not reach status 3 within DIS_TMO_US microseconds after the write, the block ends with error code 3 and still releases the domain.
- R8: A disable holds `dom_req_o` high throughout its polling, and `dom_req_o` falls exactly one cycle after the done pulse.
- R9: With `cfg_nostat_i` set, the sequence ends right after the write, with no status poll.
- R10: With a mode value of 0, neither enable nor disable performs any register read or write; only the domain handshake runs.
- R11: `standby_o` holds bit 18 of the most recent register read.
- R12: Two register reads are never closer together than POLL_GAP+2 cycles from start to start.
- R13: `done_o` is a single-cycle pulse, and `err_o` is high with it exactly when `err_code_o` is non-zero. Error codes: 0 none, 1 domain refused, 2 enable timeout, 3 disable timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_req_i | input | 1 | Command request, one cycle |
| cmd_on_i | input | 1 | 1 = enable, 0 = disable |
| cfg_mode_i | input | 2 | Mode value written on enable (1 hw-auto, 2 sw-forced, 0 no access) |
| cfg_nostat_i | input | 1 | Skip status polling |
| cmd_ack_o | output | 1 | Command accepted |
| done_o | output | 1 | Sequence finished, one cycle |
| err_o | output | 1 | Error, valid with done |
| err_code_o | output | 2 | Error code of the last sequence |
| standby_o | output | 1 | Standby flag from the last read |
| dom_req_o | output | 1 | Clock-domain request level |
| dom_gnt_i | input | 1 | Clock-domain grant |
| dom_fail_i | input | 1 | Clock-domain refusal |
| reg_rd_o | output | 1 | Register read strobe; data sampled the next cycle |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data |

## Verification
The bench builds the block with CLK_MHZ=2, EN_TMO_US=10, DIS_TMO_US=20 and POLL_GAP=3. With these values one microsecond is two cycles, so the enable timeout lands about 20 cycles after the write and the disable timeout about 40 cycles after it. Both timeout paths, the minimum duration of the enable wait, and a command rejected while busy therefore fit inside short runs. A poll gap of three still allows several polls per timeout window, which makes the spacing between reads measurable.

// File: rtl/modclk_seq.sv
module modclk_seq #(
  parameter int CLK_MHZ    = 200,
  parameter int EN_TMO_US  = 2000,
  parameter int DIS_TMO_US = 5000,
  parameter int POLL_GAP   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_req_i,
  input  logic        cmd_on_i,
  input  logic [1:0]  cfg_mode_i,
  input  logic        cfg_nostat_i,
  output logic        cmd_ack_o,
  output logic        done_o,
  output logic        err_o,
  output logic [1:0]  err_code_o,
  output logic        standby_o,
  output logic        dom_req_o,
  input  logic        dom_gnt_i,
  input  logic        dom_fail_i,
  output logic        reg_rd_o,
  output logic        reg_wr_o,
  output logic [31:0] reg_wdata_o,
  input  logic [31:0] reg_rdata_i
);
  localparam int TMAX = (EN_TMO_US > DIS_TMO_US) ? EN_TMO_US : DIS_TMO_US;
  localparam int PW   = $clog2(CLK_MHZ + 1);
  localparam int TW   = $clog2(TMAX + 1) + 1;
  localparam int GW   = $clog2(POLL_GAP + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_DOM, S_RD, S_RDW, S_WR, S_GAP, S_POLL, S_PCHK, S_FIN
  } state_t;

  state_t        st_q;
  logic          on_q, nostat_q, dom_q, sb_q;
  logic [1:0]    mode_q, code_q;
  logic [31:0]   wdata_q;
  logic [PW-1:0] pre_q;
  logic [TW-1:0] us_q;
  logic [GW-1:0] gap_q;

  wire [1:0]    stat    = reg_rdata_i[17:16];
  wire          ready   = on_q ? (stat == 2'd0 || stat == 2'd2) : (stat == 2'd3);
  wire [TW-1:0] limit   = on_q ? TW'(EN_TMO_US) : TW'(DIS_TMO_US);
  wire          expired = us_q >= limit;

  assign cmd_ack_o   = (st_q == S_IDLE) && cmd_req_i;
  assign done_o      = (st_q == S_FIN);
  assign err_o       = done_o && (code_q != 2'd0);
  assign err_code_o  = code_q;
  assign standby_o   = sb_q;
  assign dom_req_o   = dom_q;
  assign reg_rd_o    = (st_q == S_RD) || (st_q == S_POLL);
  assign reg_wr_o    = (st_q == S_WR);
  assign reg_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      on_q     <= 1'b0;
      nostat_q <= 1'b0;
      mode_q   <= 2'd0;
      code_q   <= 2'd0;
      dom_q    <= 1'b0;
      sb_q     <= 1'b0;
      wdata_q  <= '0;
      gap_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_req_i) begin
          on_q     <= cmd_on_i;
          mode_q   <= cfg_mode_i;
          nostat_q <= cfg_nostat_i;
          code_q   <= 2'd0;
          if (cmd_on_i) begin
            dom_q <= 1'b1;
            st_q  <= S_DOM;
          end else begin
            st_q <= (cfg_mode_i == 2'd0) ? S_FIN : S_RD;
          end
        end
        S_DOM: begin
          if (dom_fail_i) begin
            code_q <= 2'd1;
            st_q   <= S_FIN;
          end else if (dom_gnt_i) begin
            st_q <= (mode_q == 2'd0) ? S_FIN : S_RD;
          end
        end
        S_RD:  st_q <= S_RDW;
        S_RDW: begin
          sb_q    <= reg_rdata_i[18];
          wdata_q <= {reg_rdata_i[31:2], on_q ? mode_q : 2'd0};
          st_q    <= S_WR;
        end
        S_WR: begin
          gap_q <= '0;
          st_q  <= nostat_q ? S_FIN : S_GAP;
        end
        S_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q >= GW'(POLL_GAP - 1)) st_q <= S_POLL;
        end
        S_POLL: st_q <= S_PCHK;
        S_PCHK: begin
          sb_q  <= reg_rdata_i[18];
          gap_q <= '0;
          if (ready) begin
            st_q <= S_FIN;
          end else if (expired) begin
            code_q <= on_q ? 2'd2 : 2'd3;
            st_q   <= S_FIN;
          end else begin
            st_q <= S_GAP;
          end
        end
        S_FIN: begin
          if (!on_q || code_q == 2'd1) dom_q <= 1'b0;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (st_q == S_WR) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (pre_q >= PW'(CLK_MHZ - 1)) begin
      pre_q <= '0;
      if (!expired) us_q <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

module modclk_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic        err_o,
  input logic [1:0]  err_code_o,
  input logic        cmd_ack_o,
  input logic        dom_req_o,
  input logic        reg_rd_o,
  input logic        reg_wr_o,
  input logic [31:0] reg_wdata_o
);
  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_code_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && err_code_o != 2'd0));
  p_ack_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |=> !cmd_ack_o);
  p_rd_spacing_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);
  p_rw_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));
  p_dom_before_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_wdata_o[1:0] != 2'd0) |-> dom_req_o);
  p_dom_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dom_req_o) |-> $past(done_o));
endmodule

bind modclk_seq modclk_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .err_o(err_o),
  .err_code_o(err_code_o), .cmd_ack_o(cmd_ack_o), .dom_req_o(dom_req_o),
  .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o)
);

// File: tb/modclk_seq_tb.sv
module modclk_seq_tb;
  localparam int CLK_MHZ = 2, EN_US = 10, DIS_US = 20, GAP = 3;
  localparam logic [31:0] INIT = 32'hDEAD_BEE1;
  localparam logic [31:0] KEEP = 32'hFFF8_FFFC;

  logic clk = 0, rst_n = 0;
  logic req = 0, on = 0, nostat = 0;
  logic [1:0] mode = 0;
  logic ack, done, err, sb_o, dreq, rd, wr;
  logic [1:0] code;
  logic [31:0] wdata, rdata;
  logic gnt_en = 1, fail_en = 0;
  logic [31:0] reg_q = INIT;
  logic [1:0] st = 2'd3, on_st = 2'd0;
  logic sb = 0, follow = 1;
  int fcnt = 0;
  int checks = 0, fails = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, last_rd = -100, min_sp = 1000, wr_cyc = 0, done_cyc = 0;
  int q_code[$], q_dom[$], q_mode[$];
  logic pend = 0, prev_done = 0;
  int p_dom = 0, p_mode = 0;

  always #2.5 clk = ~clk;

  assign rdata = {reg_q[31:19], sb, st, reg_q[15:0]};

  modclk_seq #(.CLK_MHZ(CLK_MHZ), .EN_TMO_US(EN_US), .DIS_TMO_US(DIS_US), .POLL_GAP(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_req_i(req), .cmd_on_i(on), .cfg_mode_i(mode),
    .cfg_nostat_i(nostat), .cmd_ack_o(ack), .done_o(done), .err_o(err), .err_code_o(code),
    .standby_o(sb_o), .dom_req_o(dreq), .dom_gnt_i(dreq && gnt_en), .dom_fail_i(dreq && fail_en),
    .reg_rd_o(rd), .reg_wr_o(wr), .reg_wdata_o(wdata), .reg_rdata_i(rdata));

  always @(posedge clk) begin
    if (wr) begin
      reg_q <= wdata;
      if (follow) fcnt <= 4;
    end else if (fcnt > 0) begin
      fcnt <= fcnt - 1;
      if (fcnt == 1) st <= (reg_q[1:0] != 2'd0) ? on_st : 2'd3;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rd) begin
      if (cyc - last_rd < min_sp) min_sp = cyc - last_rd;
      last_rd = cyc;
      rd_cnt++;
    end
    if (wr) begin wr_cnt++; wr_cyc = cyc; end
    if (pend) begin
      pend = 0;
      chk(dreq == p_dom[0], "R8 domain after done", dreq, p_dom);
      chk(reg_q[1:0] == p_mode[1:0], "R4 mode field", reg_q[1:0], p_mode);
      chk((rdata & KEEP) == (INIT & KEEP), "R4 other bits kept", rdata & KEEP, INIT & KEEP);
    end
    if (done) begin
      done_cyc = cyc;
      chk(!prev_done, "R13 done one cycle", 1, 0);
      chk(err == (code != 0), "R13 err flag", err, code != 0);
      if (q_code.size() == 0) begin
        chk(0, "R2 unexpected done", 1, 0);
      end else begin
        int ec;
        ec = q_code.pop_front();
        p_dom = q_dom.pop_front();
        p_mode = q_mode.pop_front();
        chk(code == ec[1:0], "R13 error code", code, ec);
        pend = 1;
      end
    end
    prev_done = done;
  end

  task automatic issue(input bit o, input logic [1:0] m, input bit ns,
                       input int ec, input int ed, input int em);
    q_code.push_back(ec); q_dom.push_back(ed); q_mode.push_back(em);
    @(negedge clk);
    req = 1; on = o; mode = m; nostat = ns;
    #1 chk(ack == 1'b1, "R2 ack when idle", ack, 1);
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_end();
    while (q_code.size() != 0 || pend) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clr();
    rd_cnt = 0; wr_cnt = 0; min_sp = 1000; last_rd = -100;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dreq && !done && !err && !rd && !wr && !ack && !sb_o, "R1 reset outputs",
        {dreq, done, err, rd, wr, ack, sb_o}, 0);
    rst_n = 1;
    @(negedge clk);

    on_st = 2'd0; follow = 1;
    clr(); issue(1, 2'd2, 0, 0, 1, 2); wait_end();
    chk(rd_cnt >= 2, "R5 enable polled", rd_cnt, 2);

    clr(); issue(0, 2'd2, 0, 0, 0, 0); wait_end();
    chk(st == 2'd3, "R5 disable reached status 3", st, 3);
    chk(min_sp >= GAP + 2, "R12 read spacing", min_sp, GAP + 2);

    on_st = 2'd2;
    clr(); issue(1, 2'd1, 0, 0, 1, 1); wait_end();

    follow = 0;
    clr(); issue(0, 2'd1, 1, 0, 0, 0); wait_end();
    chk(rd_cnt == 1, "R9 no poll with nostat", rd_cnt, 1);

    gnt_en = 0; fail_en = 1;
    clr(); issue(1, 2'd2, 0, 1, 0, 0); wait_end();
    chk(rd_cnt == 0 && wr_cnt == 0, "R3 no access on domain refusal", rd_cnt + wr_cnt, 0);
    gnt_en = 1; fail_en = 0;

    st = 2'd3;
    clr(); issue(1, 2'd2, 0, 2, 1, 2);
    repeat (5) @(negedge clk);
    req = 1; on = 0; mode = 2'd2;
    #1 chk(ack == 1'b0, "R2 busy command ignored", ack, 0);
    @(negedge clk); req = 0;
    wait_end();
    chk(done_cyc - wr_cyc >= CLK_MHZ * EN_US, "R6 enable timeout length",
        done_cyc - wr_cyc, CLK_MHZ * EN_US);

    st = 2'd0;
    clr(); issue(0, 2'd2, 0, 3, 0, 0);
    while (rd_cnt < 2) @(negedge clk);
    chk(dreq == 1'b1, "R8 domain held while polling", dreq, 1);
    wait_end();
    chk(done_cyc - wr_cyc >= CLK_MHZ * DIS_US, "R7 disable timeout length",
        done_cyc - wr_cyc, CLK_MHZ * DIS_US);

    clr(); issue(1, 2'd0, 0, 0, 1, 0); wait_end();
    chk(rd_cnt == 0 && wr_cnt == 0, "R10 mode 0 enable no access", rd_cnt + wr_cnt, 0);
    clr(); issue(0, 2'd0, 0, 0, 0, 0); wait_end();
    chk(rd_cnt == 0 && wr_cnt == 0, "R10 mode 0 disable no access", rd_cnt + wr_cnt, 0);

    sb = 1;
    clr(); issue(1, 2'd2, 1, 0, 1, 2); wait_end();
    chk(sb_o == 1'b1, "R11 standby set", sb_o, 1);
    sb = 0;
    clr(); issue(0, 2'd2, 1, 0, 0, 0); wait_end();
    chk(sb_o == 1'b0, "R11 standby clear", sb_o, 0);

    repeat (20) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule